// File: doc/BRIEF.md
# Auto Acknowledge Transaction Sequencer

This block runs a complete acknowledged radio transfer without help from the host. On a transmit request it wakes the oscillator, waits for the synthesizer to settle, and keys the transmitter while the framer sends the buffered packet. It then turns the receiver on to listen for a handshake, and ends in the configured end state once the handshake arrives or the wait runs out. On a receive request it listens for packets, answers each valid one with an acknowledge packet and goes back to listening.

The radio front end, the framer and the packet buffers sit outside. The block reaches them only through level controls (oscillator enable, synthesizer start, transmit enable, receive enable, an acknowledge-select line and a buffer-store enable) and through single-cycle status inputs. Events are recorded in sticky flags that the host clears, and the OR of the flags drives an interrupt line. All radio controls are decoded from the registered state, so each one changes on the clock edge that follows the input that causes the change.

Top module: `ackseq_top`

## Requirements
- R1: After reset the block is asleep. Every radio control output is low, all flags are zero and `irq` is low.
- R2: A `cmd_tx_go` pulse while asleep raises `osc_en` and waits for `osc_ready`. The block then holds `synth_start` until `synth_ready`, and then holds `tx_en` with `tx_sel_ack` low until `pkt_sent`.
- R3: After `pkt_sent` the block waits for a handshake with `rx_en` high and `rx_store_en` low. An `ack_rcvd` in that wait sets the done flag (bit 0) and moves to the end state.
- R4: The handshake wait lasts exactly `cfg_ack_ticks`+1 cycles when no acknowledge arrives. It then sets the timeout flag (bit 1) and moves to the end state. An acknowledge in the last cycle of the wait wins over the timeout.
- R5: With `cfg_end_sleep`=1 the end state is sleep (all outputs low). With `cfg_end_sleep`=0 it is idle: `osc_en` stays high and the other outputs are low. A request issued from idle goes straight to the synthesizer wait without waiting for `osc_ready`.
- R6: A `cmd_rx_go` pulse leads, after the oscillator and synthesizer steps, to listening with `rx_en` and `rx_store_en` high. A `rx_valid` there sets the packet flag (bit 2) and sends an acknowledge with `tx_en` and `tx_sel_ack` high and `rx_store_en` low. After `pkt_sent` the block listens again.
- R7: `cmd_force_end` has priority over every other input. From any state it moves the block to the end state selected by `cfg_end_sleep`. A transmit or receive request then wakes the block from sleep.
- R8: Leaving the oscillator wait sets the oscillator flag (bit 4) only when `cfg_osc_irq_en` is 1.
- R9: The flags stay set until the host writes a 1 to the matching `flag_clr` bit. A flag being set in the same cycle wins over the clear. `irq` is the OR of all flags.
- R10: A transmit or receive request while a transaction is in progress is ignored and sets the busy flag (bit 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_end_sleep | input | 1 | End state select: 1 sleep, 0 idle |
| cfg_osc_irq_en | input | 1 | Enables the oscillator-stable flag |
| cfg_ack_ticks | input | TMR_W | Handshake wait length minus one, in cycles |
| cmd_tx_go | input | 1 | Start a transmit transaction (pulse) |
| cmd_rx_go | input | 1 | Start a receive transaction (pulse) |
| cmd_force_end | input | 1 | Force the end state (pulse) |
| flag_clr | input | 5 | Write-one-to-clear mask for the flags |
| osc_ready | input | 1 | Oscillator is stable |
| synth_ready | input | 1 | Synthesizer has settled |
| pkt_sent | input | 1 | Framer finished sending a packet |
| rx_valid | input | 1 | A valid data packet was received |
| ack_rcvd | input | 1 | A handshake packet was received |
| osc_en | output | 1 | Oscillator enable |
| synth_start | output | 1 | Synthesizer start |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| tx_sel_ack | output | 1 | Transmit an acknowledge instead of the buffer |
| rx_store_en | output | 1 | Received data may be written to the receive buffer |
| flags | output | 5 | Sticky flags: done, timeout, packet, busy, oscillator |
| irq | output | 1 | OR of the flags |

## Verification
Every control output and every flag is due one clock edge after the input that causes it. The bench drives inputs on the falling edge and reads results on the next falling edge, so each check falls in the first full cycle after the edge that acts. The handshake wait is timed by counting falling edges while the wait pattern is present on the outputs, and the count is compared with `cfg_ack_ticks`+1. Results that must not change, such as ignored requests and acknowledge transmission, are read on the outputs one cycle after the stimulus.

// File: rtl/ackseq_pkg.sv
package ackseq_pkg;
  typedef enum logic [2:0] {
    S_SLEEP, S_IDLE, S_OSCW, S_SYNW, S_TXD, S_ACKW, S_RXW, S_TXACK
  } seq_st_e;

  localparam int NFLAG   = 5;
  localparam int FL_DONE = 0;
  localparam int FL_TOUT = 1;
  localparam int FL_RXPK = 2;
  localparam int FL_BUSY = 3;
  localparam int FL_OSC  = 4;

  typedef struct packed {
    logic osc_en;
    logic synth_start;
    logic tx_en;
    logic rx_en;
    logic tx_sel_ack;
    logic rx_store_en;
  } radio_ctl_t;

  function automatic radio_ctl_t st_drive(seq_st_e s);
    radio_ctl_t c;
    c = '0;
    c.osc_en      = (s != S_SLEEP);
    c.synth_start = (s == S_SYNW);
    c.tx_en       = (s == S_TXD) || (s == S_TXACK);
    c.rx_en       = (s == S_ACKW) || (s == S_RXW);
    c.tx_sel_ack  = (s == S_TXACK);
    c.rx_store_en = (s == S_RXW);
    return c;
  endfunction

  function automatic logic st_active(seq_st_e s);
    return (s != S_SLEEP) && (s != S_IDLE);
  endfunction
endpackage

// File: rtl/ackseq_timer.sv
module ackseq_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [TMR_W-1:0] load_val,
  output logic             expire
);
  logic [TMR_W-1:0] cnt_q;

  function automatic logic [TMR_W-1:0] tmr_next(logic [TMR_W-1:0] c, logic ld,
                                                 logic [TMR_W-1:0] v, logic rn);
    if (ld)             return v;
    if (rn && c != '0)  return c - 1'b1;
    return c;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= tmr_next(cnt_q, load, load_val, run);

  assign expire = run && (cnt_q == '0);

  // checker: independent up-counter of cycles since load
  logic [TMR_W-1:0] chk_elapsed, chk_val;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      chk_elapsed <= '0;
      chk_val     <= '0;
    end else if (load) begin
      chk_elapsed <= '0;
      chk_val     <= load_val;
    end else if (run && chk_elapsed != chk_val) begin
      chk_elapsed <= chk_elapsed + 1'b1;
    end

  a_r4_expire_after_window: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (chk_elapsed == chk_val));
endmodule

// File: rtl/ackseq_flags.sv
module ackseq_flags #(
  parameter int NF = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set,
  input  logic [NF-1:0] clr,
  output logic [NF-1:0] flags_q
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr) | set;

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flags_q) & ~$past(clr) & ~flags_q) == '0));
endmodule

// File: rtl/ackseq_fsm.sv
module ackseq_fsm
  import ackseq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cfg_end_sleep,
  input  logic    cmd_tx_go,
  input  logic    cmd_rx_go,
  input  logic    cmd_force_end,
  input  logic    osc_ready,
  input  logic    synth_ready,
  input  logic    pkt_sent,
  input  logic    rx_valid,
  input  logic    ack_rcvd,
  input  logic    tmr_expire,
  output seq_st_e state,
  output logic    tmr_load,
  output logic    ev_done,
  output logic    ev_timeout,
  output logic    ev_rx_pkt,
  output logic    ev_busy,
  output logic    ev_osc_up
);
  seq_st_e nxt, end_st;
  logic    kind_rx_q, kind_rx_d, any_go;

  assign end_st = cfg_end_sleep ? S_SLEEP : S_IDLE;
  assign any_go = cmd_tx_go || cmd_rx_go;

  always_comb begin
    nxt        = state;
    kind_rx_d  = kind_rx_q;
    ev_done    = 1'b0;
    ev_timeout = 1'b0;
    ev_rx_pkt  = 1'b0;
    ev_osc_up  = 1'b0;
    if (cmd_force_end) begin
      nxt = end_st;
    end else begin
      case (state)
        S_SLEEP, S_IDLE: if (any_go) begin
          nxt       = (state == S_SLEEP) ? S_OSCW : S_SYNW;
          kind_rx_d = !cmd_tx_go;
        end
        S_OSCW:  if (osc_ready) begin
          nxt       = S_SYNW;
          ev_osc_up = 1'b1;
        end
        S_SYNW:  if (synth_ready) nxt = kind_rx_q ? S_RXW : S_TXD;
        S_TXD:   if (pkt_sent) nxt = S_ACKW;
        S_ACKW:  if (ack_rcvd) begin
          nxt     = end_st;
          ev_done = 1'b1;
        end else if (tmr_expire) begin
          nxt        = end_st;
          ev_timeout = 1'b1;
        end
        S_RXW:   if (rx_valid) begin
          nxt       = S_TXACK;
          ev_rx_pkt = 1'b1;
        end
        S_TXACK: if (pkt_sent) nxt = S_RXW;
        default: nxt = S_SLEEP;
      endcase
    end
  end

  assign ev_busy  = st_active(state) && any_go;
  assign tmr_load = (state != S_ACKW) && (nxt == S_ACKW);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state     <= S_SLEEP;
      kind_rx_q <= 1'b0;
    end else begin
      state     <= nxt;
      kind_rx_q <= kind_rx_d;
    end

  a_r7_force_end: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_force_end |=> !st_active(state));
  a_r3_ackw_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ACKW && $past(state) != S_ACKW) |-> $past(pkt_sent));
  a_r6_txack_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TXACK && $past(state) != S_TXACK) |-> $past(rx_valid));
  a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st_active(state) && any_go && !cmd_force_end && state != S_OSCW && state != S_SYNW
     && !pkt_sent && !rx_valid && !ack_rcvd && !tmr_expire) |=> $stable(state));
endmodule

// File: rtl/ackseq_top.sv
module ackseq_top
  import ackseq_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_end_sleep,
  input  logic             cfg_osc_irq_en,
  input  logic [TMR_W-1:0] cfg_ack_ticks,
  input  logic             cmd_tx_go,
  input  logic             cmd_rx_go,
  input  logic             cmd_force_end,
  input  logic [4:0]       flag_clr,
  input  logic             osc_ready,
  input  logic             synth_ready,
  input  logic             pkt_sent,
  input  logic             rx_valid,
  input  logic             ack_rcvd,
  output logic             osc_en,
  output logic             synth_start,
  output logic             tx_en,
  output logic             rx_en,
  output logic             tx_sel_ack,
  output logic             rx_store_en,
  output logic [4:0]       flags,
  output logic             irq
);
  seq_st_e    state;
  radio_ctl_t ctl;
  logic       tmr_load, tmr_expire;
  logic       ev_done, ev_timeout, ev_rx_pkt, ev_busy, ev_osc_up;
  logic [NFLAG-1:0] flag_set;

  ackseq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cfg_end_sleep(cfg_end_sleep),
    .cmd_tx_go(cmd_tx_go), .cmd_rx_go(cmd_rx_go), .cmd_force_end(cmd_force_end),
    .osc_ready(osc_ready), .synth_ready(synth_ready), .pkt_sent(pkt_sent),
    .rx_valid(rx_valid), .ack_rcvd(ack_rcvd), .tmr_expire(tmr_expire),
    .state(state), .tmr_load(tmr_load), .ev_done(ev_done), .ev_timeout(ev_timeout),
    .ev_rx_pkt(ev_rx_pkt), .ev_busy(ev_busy), .ev_osc_up(ev_osc_up)
  );

  ackseq_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .run(state == S_ACKW),
    .load_val(cfg_ack_ticks), .expire(tmr_expire)
  );

  always_comb begin
    flag_set          = '0;
    flag_set[FL_DONE] = ev_done;
    flag_set[FL_TOUT] = ev_timeout;
    flag_set[FL_RXPK] = ev_rx_pkt;
    flag_set[FL_BUSY] = ev_busy;
    flag_set[FL_OSC]  = ev_osc_up && cfg_osc_irq_en;
  end

  ackseq_flags #(.NF(NFLAG)) u_flg (
    .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr), .flags_q(flags)
  );

  assign ctl         = st_drive(state);
  assign osc_en      = ctl.osc_en;
  assign synth_start = ctl.synth_start;
  assign tx_en       = ctl.tx_en;
  assign rx_en       = ctl.rx_en;
  assign tx_sel_ack  = ctl.tx_sel_ack;
  assign rx_store_en = ctl.rx_store_en;
  assign irq         = |flags;

  a_r8_osc_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[FL_OSC]) |-> ($past(osc_ready) && $past(cfg_osc_irq_en)));
  a_r6_ack_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sel_ack |-> (tx_en && !rx_store_en && !rx_en));
endmodule

// File: tb/sim_ackseq_top.sv
`timescale 1ns/1ps
module sim_ackseq_top;
  localparam int TW = 16;
  localparam logic [5:0] O_SLEEP = 6'b000000, O_IDLE = 6'b100000, O_SYNW = 6'b110000,
                         O_TXD = 6'b101000, O_ACKW = 6'b100100, O_RXW = 6'b100101,
                         O_TXACK = 6'b101010;

  logic clk = 0, rst_n = 0;
  logic cfg_end_sleep = 0, cfg_osc_irq_en = 0;
  logic [TW-1:0] cfg_ack_ticks = '0;
  logic cmd_tx_go = 0, cmd_rx_go = 0, cmd_force_end = 0;
  logic [4:0] flag_clr = '0;
  logic osc_ready = 0, synth_ready = 0, pkt_sent = 0, rx_valid = 0, ack_rcvd = 0;
  logic osc_en, synth_start, tx_en, rx_en, tx_sel_ack, rx_store_en, irq;
  logic [4:0] flags;
  logic [5:0] obs;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  ackseq_top #(.TMR_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_end_sleep(cfg_end_sleep), .cfg_osc_irq_en(cfg_osc_irq_en),
    .cfg_ack_ticks(cfg_ack_ticks), .cmd_tx_go(cmd_tx_go), .cmd_rx_go(cmd_rx_go),
    .cmd_force_end(cmd_force_end), .flag_clr(flag_clr), .osc_ready(osc_ready),
    .synth_ready(synth_ready), .pkt_sent(pkt_sent), .rx_valid(rx_valid), .ack_rcvd(ack_rcvd),
    .osc_en(osc_en), .synth_start(synth_start), .tx_en(tx_en), .rx_en(rx_en),
    .tx_sel_ack(tx_sel_ack), .rx_store_en(rx_store_en), .flags(flags), .irq(irq)
  );
  assign obs = {osc_en, synth_start, tx_en, rx_en, tx_sel_ack, rx_store_en};

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    flag_clr = 5'h1F; tick(); flag_clr = '0;
  endtask

  task automatic t_reset();
    chk("R1 outputs", obs, O_SLEEP);
    chk("R1 flags", flags, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_tx_ack();
    cfg_end_sleep = 1; cfg_osc_irq_en = 1; cfg_ack_ticks = 5;
    cmd_tx_go = 1; tick(); cmd_tx_go = 0;
    chk("R2 osc wait", obs, O_IDLE);
    tick();
    chk("R2 osc hold", obs, O_IDLE);
    osc_ready = 1; tick();
    chk("R2 synth wait", obs, O_SYNW);
    chk("R8 osc flag", flags[4], 1);
    tick();
    chk("R2 synth hold", obs, O_SYNW);
    synth_ready = 1; tick();
    chk("R2 tx data", obs, O_TXD);
    pkt_sent = 1; tick(); pkt_sent = 0;
    chk("R3 ack wait", obs, O_ACKW);
    ack_rcvd = 1; tick(); ack_rcvd = 0;
    chk("R5 end sleep", obs, O_SLEEP);
    chk("R3 done flag", flags[0], 1);
    chk("R9 irq", irq, 1);
    clear_all();
    chk("R9 cleared", flags, 0);
  endtask

  task automatic t_timeout();
    cfg_end_sleep = 0; cfg_osc_irq_en = 0; cfg_ack_ticks = 3;
    cmd_tx_go = 1; tick(); cmd_tx_go = 0;
    tick();
    chk("R2 synth after osc", obs, O_SYNW);
    chk("R8 osc flag off", flags[4], 0);
    tick();
    chk("R2 tx data", obs, O_TXD);
    pkt_sent = 1; tick(); pkt_sent = 0;
    begin
      int n = 0;
      while (obs == O_ACKW && n < 20) begin n++; tick(); end
      chk("R4 wait length", n, 4);
    end
    chk("R5 end idle", obs, O_IDLE);
    chk("R4 timeout flag", flags[1], 1);
    chk("R4 no done flag", flags[0], 0);
  endtask

  task automatic t_ack_race();
    clear_all();
    cfg_ack_ticks = 0; osc_ready = 0;
    cmd_tx_go = 1; tick(); cmd_tx_go = 0;
    chk("R5 idle skips osc", obs, O_SYNW);
    tick();
    chk("R2 tx data", obs, O_TXD);
    pkt_sent = 1; tick(); pkt_sent = 0;
    chk("R3 ack wait", obs, O_ACKW);
    ack_rcvd = 1; flag_clr = 5'h01; tick(); ack_rcvd = 0; flag_clr = '0;
    chk("R4 ack wins", flags[1:0], 2'b01);
    chk("R9 set beats clear", flags[0], 1);
    chk("R5 end idle", obs, O_IDLE);
  endtask

  task automatic t_rx_mode();
    clear_all();
    cmd_rx_go = 1; tick(); cmd_rx_go = 0;
    chk("R6 synth", obs, O_SYNW);
    tick();
    chk("R6 listen", obs, O_RXW);
    cmd_tx_go = 1; tick(); cmd_tx_go = 0;
    chk("R10 ignored", obs, O_RXW);
    chk("R10 busy flag", flags[3], 1);
    rx_valid = 1; tick(); rx_valid = 0;
    chk("R6 ack send", obs, O_TXACK);
    chk("R6 packet flag", flags[2], 1);
    tick();
    chk("R6 ack hold", obs, O_TXACK);
    pkt_sent = 1; tick(); pkt_sent = 0;
    chk("R6 listen again", obs, O_RXW);
  endtask

  task automatic t_force();
    cfg_end_sleep = 1;
    cmd_force_end = 1; tick(); cmd_force_end = 0;
    chk("R7 forced sleep", obs, O_SLEEP);
    cmd_rx_go = 1; tick(); cmd_rx_go = 0;
    chk("R7 wake", obs, O_IDLE);
    tick();
    chk("R7 osc wait held", obs, O_IDLE);
    cfg_end_sleep = 0;
    cmd_force_end = 1; osc_ready = 1; tick(); cmd_force_end = 0;
    chk("R7 forced idle", obs, O_IDLE);
    cmd_rx_go = 1; tick(); cmd_rx_go = 0;
    chk("R7 idle restart", obs, O_SYNW);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_tx_ack();
    t_timeout();
    t_ack_race();
    t_rx_mode();
    t_force();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule